// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns one read or write command on a double-data-rate SDRAM data path into the column addresses of its burst. A command supplies a start column, a burst length code and a wrap order. Wrap order is either a linear count or an XOR pattern. The data path moves two beats per clock, so the block presents one beat pair on every clock of the burst: the even beat and the odd beat, side by side. A strobe marks each valid pair, and a flag marks the pair that closes the burst.

Every beat stays inside the aligned group of columns that the burst length defines. The block wraps at the group edge and never carries into the column bits above it. A command that arrives while a burst is still running takes over on the next clock. The burst that was running ends with the pair already on the outputs. This single rule covers two cases. A new command issued on the closing pair joins the two bursts with no gap. A new command issued earlier cuts the running burst short at a pair boundary.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is low, and on the first clock after it rises with no command, `pair_valid` and `pair_last` are 0.
- R2: A command sampled on a clock edge makes its first pair visible after that edge. The burst then shows one pair per clock for length/2 clocks. With no new command, `pair_valid` is 0 on the clock after the closing pair.
- R3: `cmd_len` selects the burst length: 2'b00 gives 2 beats, 2'b01 gives 4 and 2'b10 gives 8. The spare code 2'b11 behaves as 8.
- R4: Column bits at and above bit log2(length) of every beat equal those of the start column, so the burst stays in its aligned group.
- R5: With `cmd_ileave`=0, beat k has low bits (start low bits + k) modulo length.
- R6: With `cmd_ileave`=1, beat k has low bits (start low bits XOR k).
- R7: Beat 2p of a burst appears on `col_even` and beat 2p+1 on `col_odd` in pair p. `pair_last` is 1 only on the final pair of a burst.
- R8: A command that arrives while a burst is showing ends that burst after the pair currently on the outputs. The new burst's pair 0 follows on the next clock. A command on the closing pair therefore chains the two bursts with no gap.
- R9: Changes on `cmd_col`, `cmd_len` and `cmd_ileave` while `cmd_start` is 0 have no effect on a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | A read or write command is issued this clock |
| cmd_col | input | COL_W | Start column of the command |
| cmd_len | input | 2 | Burst length code (see R3) |
| cmd_ileave | input | 1 | 0 selects linear wrap order, 1 selects XOR wrap order |
| pair_valid | output | 1 | A beat pair is presented this clock |
| pair_last | output | 1 | The presented pair closes the burst |
| col_even | output | COL_W | Column of the first beat of the pair |
| col_odd | output | COL_W | Column of the second beat of the pair |

## Verification
The first pattern is an exhaustive sweep over every start offset inside an 8-column group, both wrap orders and all four length codes. The upper column bits change from burst to burst. This sweep separates linear wrap from XOR wrap: the two agree at offset 0 and differ at most other offsets. It also catches a carry that escapes the aligned group, and it shows that the spare length code acts as 8. Commands are issued on every clock, in the middle of a burst and on the closing pair, to separate a truncation from a concatenation. In a further pattern the command inputs change while no command is issued, which shows that the burst is captured only when a command arrives. A reset in the middle of a burst completes the set.

// File: rtl/ddr_colgen_pkg.sv
package ddr_colgen_pkg;

  // log2 of the longest burst; offset bits inside the widest aligned group
  localparam int OFS_W  = 3;
  // bits needed to index a beat pair inside the longest burst
  localparam int PIDX_W = OFS_W - 1;

  typedef logic [1:0] blen_code_t;

  localparam blen_code_t BLEN_2 = 2'b00;
  localparam blen_code_t BLEN_4 = 2'b01;
  localparam blen_code_t BLEN_8 = 2'b10;

  // offset mask for a length code; the spare code falls back to the longest burst
  function automatic logic [OFS_W-1:0] len_mask(input blen_code_t code);
    logic [OFS_W-1:0] m;
    case (code)
      BLEN_2:  m = 3'b001;
      BLEN_4:  m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/colgen_ctl.sv
module colgen_ctl
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  blen_code_t        len_sel,
  input  logic              ileave,
  output logic              active,
  output logic              last,
  output logic [COL_W-1:0]  base,
  output logic [OFS_W-1:0]  blk_mask,
  output logic              il,
  output logic [PIDX_W-1:0] pidx
);

  logic              act_q, act_d;
  logic [COL_W-1:0]  base_q;
  logic [OFS_W-1:0]  mask_q;
  logic              il_q;
  logic [PIDX_W-1:0] pidx_q, pidx_d;
  logic              last_w;
  logic              ld_en, adv_en;

  // final pair index of the burst is the offset mask without its beat bit
  assign last_w = act_q && (pidx_q == mask_q[OFS_W-1:1]);

  assign ld_en  = start;
  assign adv_en = act_q && !last_w && !start;

  always_comb begin
    act_d  = act_q;
    pidx_d = pidx_q;
    if (ld_en) begin
      act_d  = 1'b1;
      pidx_d = '0;
    end else if (adv_en) begin
      pidx_d = pidx_q + 1'b1;
    end else if (last_w) begin
      act_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pidx_q <= '0;
      base_q <= '0;
      mask_q <= '0;
      il_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      if (ld_en || adv_en) pidx_q <= pidx_d;
      if (ld_en) begin
        base_q <= start_col;
        mask_q <= len_mask(len_sel);
        il_q   <= ileave;
      end
    end
  end

  assign active   = act_q;
  assign last     = last_w;
  assign base     = base_q;
  assign blk_mask = mask_q;
  assign il       = il_q;
  assign pidx     = pidx_q;

  // R8: a command always opens a fresh burst at pair 0 on the next clock
  a_r8_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && pidx == '0));

  // R2: the burst ends after its closing pair unless a command follows
  a_r2_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last && !start) |=> !active);

  // R2: one pair per clock while the burst runs
  a_r2_pair_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !start) |=> (active && pidx == $past(pidx) + 1'b1));

  // R9: captured command fields stay put until the next command
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> ($stable(base) && $stable(blk_mask) && $stable(il)));

endmodule

// File: rtl/colgen_beat.sv
module colgen_beat
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BEAT  = 0
) (
  input  logic [COL_W-1:0]  base,
  input  logic [OFS_W-1:0]  blk_mask,
  input  logic              il,
  input  logic [PIDX_W-1:0] pidx,
  output logic [COL_W-1:0]  col
);

  logic [OFS_W-1:0] beat_idx;
  logic [OFS_W-1:0] ofs_lin;
  logic [OFS_W-1:0] ofs_xor;
  logic [OFS_W-1:0] ofs_sel;

  assign beat_idx = {pidx, 1'(BEAT)};
  // modulo-8 sum; masking reduces it modulo the burst length
  assign ofs_lin  = base[OFS_W-1:0] + beat_idx;
  assign ofs_xor  = base[OFS_W-1:0] ^ beat_idx;
  assign ofs_sel  = il ? ofs_xor : ofs_lin;

  assign col = {base[COL_W-1:OFS_W],
                (base[OFS_W-1:0] & ~blk_mask) | (ofs_sel & blk_mask)};

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cmd_len,
  input  logic             cmd_ileave,
  output logic             pair_valid,
  output logic             pair_last,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd
);

  localparam int BEATS_PER_CLK = 2;

  logic              act;
  logic              lst;
  logic [COL_W-1:0]  base;
  logic [OFS_W-1:0]  blk_mask;
  logic              il;
  logic [PIDX_W-1:0] pidx;
  logic [COL_W-1:0]  beat_col [BEATS_PER_CLK];

  colgen_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .start_col (cmd_col),
    .len_sel   (cmd_len),
    .ileave    (cmd_ileave),
    .active    (act),
    .last      (lst),
    .base      (base),
    .blk_mask  (blk_mask),
    .il        (il),
    .pidx      (pidx)
  );

  for (genvar g = 0; g < BEATS_PER_CLK; g++) begin : g_beat
    colgen_beat #(.COL_W(COL_W), .BEAT(g)) u_beat (
      .base     (base),
      .blk_mask (blk_mask),
      .il       (il),
      .pidx     (pidx),
      .col      (beat_col[g])
    );
  end

  assign pair_valid = act;
  assign pair_last  = lst;
  assign col_even   = beat_col[0];
  assign col_odd    = beat_col[1];

  // R4: both beats of a pair share the widest aligned group
  a_r4_same_group: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (col_even[COL_W-1:OFS_W] == col_odd[COL_W-1:OFS_W]));

  // R7: the two beats of a pair are distinct columns
  a_r7_beats_differ: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (col_even != col_odd));

  // R7: the closing flag only accompanies a valid pair
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |-> pair_valid);

endmodule

// File: tb/tb_ddr_burst_colgen.sv
`timescale 1ns/1ps
module tb_ddr_burst_colgen;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_start;
  logic [COL_W-1:0] cmd_col;
  logic [1:0]       cmd_len;
  logic             cmd_ileave;
  logic             pair_valid;
  logic             pair_last;
  logic [COL_W-1:0] col_even;
  logic [COL_W-1:0] col_odd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int qe[$];
  int qo[$];

  always #5 clk = ~clk;

  ddr_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
    .cmd_len(cmd_len), .cmd_ileave(cmd_ileave), .pair_valid(pair_valid),
    .pair_last(pair_last), .col_even(col_even), .col_odd(col_odd)
  );

  function automatic int beats_of(input int code);
    if (code == 0) return 2;
    if (code == 1) return 4;
    return 8;
  endfunction

  function automatic int expect_col(input int col, input int code, input int typ, input int k);
    int n, grp, ofs, pos;
    n   = beats_of(code);
    grp = col - (col % n);
    ofs = col % n;
    pos = typ ? (ofs ^ k) : ((ofs + k) % n);
    return grp + pos;
  endfunction

  // reference: front of the queues is the pair currently on the outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      qe.delete();
      qo.delete();
    end else if (cmd_start) begin
      qe.delete();
      qo.delete();
      for (int p = 0; p < beats_of(int'(cmd_len)) / 2; p++) begin
        qe.push_back(expect_col(int'(cmd_col), int'(cmd_len), int'(cmd_ileave), 2*p));
        qo.push_back(expect_col(int'(cmd_col), int'(cmd_len), int'(cmd_ileave), 2*p+1));
      end
    end else if (qe.size() > 0) begin
      void'(qe.pop_front());
      void'(qo.pop_front());
    end
  end

  task automatic compare(input string tag);
    bit ev, el;
    int ee, eo;
    ev = (qe.size() > 0);
    el = (qe.size() == 1);
    ee = ev ? qe[0] : 0;
    eo = ev ? qo[0] : 0;
    n_cmp++;
    if (pair_valid !== ev || pair_last !== el ||
        (ev && (int'(col_even) != ee || int'(col_odd) != eo))) begin
      n_bad++;
      $display("FAIL %s: got valid=%0d last=%0d even=%0h odd=%0h exp valid=%0d last=%0d even=%0h odd=%0h",
               tag, pair_valid, pair_last, col_even, col_odd, ev, el, ee, eo);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input bit s, input int col, input int code, input int typ, input string tag);
    cmd_start  = s;
    cmd_col    = COL_W'(col);
    cmd_len    = 2'(code);
    cmd_ileave = typ[0];
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no end of test, exp end within limit");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_col = '0; cmd_len = '0; cmd_ileave = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 after reset");

    // exhaustive sweep: R2 R3 R4 R5 R6 R7
    for (int typ = 0; typ < 2; typ++)
      for (int code = 0; code < 4; code++)
        for (int ofs = 0; ofs < 8; ofs++) begin
          int col;
          string tag;
          col = (((typ*4 + code)*3 + ofs + 1) % 32) * 8 + ofs;
          tag = (code == 3) ? "R3 spare code" : (typ ? "R6/R4/R7 xor order" : "R5/R4/R7 linear order");
          step(1, col, code, typ, tag);
          for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R2 pair per clock");
        end

    // truncation mid burst
    step(1, 8'h35, 2, 0, "R8 first burst");
    step(0, 0, 0, 0, "R8 first burst");
    step(1, 8'hC6, 1, 1, "R8 truncation");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R8 after truncation");

    // concatenation on the closing pair
    step(1, 8'h4B, 1, 0, "R8 chain a");
    step(0, 0, 0, 0, "R8 chain a");
    step(1, 8'h9D, 1, 1, "R8 chain b");
    step(0, 0, 0, 0, "R8 chain b");
    step(0, 0, 0, 0, "R2 gap");

    // command every clock
    step(1, 8'h11, 2, 1, "R8 every clock");
    step(1, 8'h27, 0, 0, "R8 every clock");
    step(1, 8'hF2, 3, 0, "R8 every clock");
    step(1, 8'h6F, 2, 1, "R8 every clock");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R8 drain");

    // inputs change without a command
    step(1, 8'h13, 2, 0, "R9 capture");
    step(0, 8'hFF, 0, 1, "R9 ignored");
    step(0, 8'h00, 1, 1, "R9 ignored");
    step(0, 8'hA5, 3, 0, "R9 ignored");
    step(0, 8'h5A, 0, 1, "R9 ignored");

    // reset in the middle of a burst
    step(1, 8'h81, 2, 1, "R1 burst before reset");
    cmd_start = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare("R1 reset mid burst");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 after second reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule